// File: doc/BRIEF.md
# Variable Length Bitstream Reader

This block reads a little-endian byte stream as a sequence of bit fields whose length software chooses between 1 and 16 bits. A host programs a 24-bit byte address and a control register. The block keeps a 4-bit bit offset inside the current 16-bit unit. On every advance it adds the field length to the offset and moves the address forward by two bytes when the sum reaches 16. It then fetches four consecutive bytes from an external synchronous memory and shifts the resulting 32-bit word right by the new offset. The low 16 bits of the shifted word form the output window, which the host reads as two bytes.

An advance happens in two cases. The first is a write of the control register. The second is a read of the window's high byte while auto-advance is enabled, in which case the byte that was current before the advance is returned. Writing any address byte restarts the stream at bit offset 0 and refetches without moving. While a fetch is in flight the block reports busy. It ignores register writes during that time, and reads return the last completed window.

Top module: `bitstream_window_reader`

## Requirements
- R1: After reset the window is 0, `busy` is low, no memory request is made, and reads of either window byte return 0.
- R2: A write with `wr_sel` 1, 2 or 3 loads address bits 7:0, 15:8 or 23:16 respectively. It sets the bit offset to 0 and fetches at the new address. The window becomes the low 16 bits of the unshifted 32-bit little-endian word there (byte at the address in bits 7:0).
- R3: A write with `wr_sel` 0 stores the control byte. Bits 3:0 give the field length L, where 0 means 16. With offset P, s = P + L. If s >= 16 the address grows by 2. The new offset is s mod 16, and the window is the word at the (possibly moved) address shifted right by the new offset.
- R4: When control bit 7 is set, a read with `rd_sel` 1 returns the current high window byte and then performs the R3 step using the stored length.
- R5: When control bit 7 is clear, reads of either byte leave the address, the offset and the window unchanged.
- R6: Each fetch issues exactly four memory requests at consecutive addresses, modulo 2^24. Requests are made only while `busy` is high. `busy` is high on the cycle after the triggering access and stays high until the window is updated.
- R7: Register writes presented while `busy` is high have no effect.
- R8: A read while `busy` is high returns a byte of the last completed window.
- R9: `rd_sel` 0 selects window bits 7:0 and `rd_sel` 1 selects bits 15:8. `rd_data` is registered: it updates on the clock edge that samples `rd_en` and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1..3 address bytes low to high |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Window read strobe |
| rd_sel | input | 1 | Window byte select: 0 low, 1 high |
| rd_data | output | 8 | Registered read data |
| busy | output | 1 | Fetch in progress |
| mem_req | output | 1 | Memory byte read request |
| mem_addr | output | 24 | Memory byte address |
| mem_rdata | input | 8 | Memory data, valid the cycle after a request |

## Verification
The assertions check the following on every cycle: requests appear only while busy, successive requests step the address by one (wrapping at 2^24), each fetch makes exactly four requests, `rd_data` holds when no read is strobed, and the reset state. The window contents cannot be checked that way. These are the shift by the accumulated offset, the two-byte address step when the offset crosses 16, the length-0-means-16 rule, auto-advance on a high-byte read, and the dropping of writes while busy. The bench scenarios show them by comparing every window against a reference model of address and offset, including a stream that wraps past the top of the address space.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  localparam int unsigned CTRL_SEL      = 0;  // wr_sel value of the control byte
  localparam int unsigned CTRL_AUTO_BIT = 7;  // auto-advance enable bit
  typedef logic [7:0] byte_t;
endpackage

// File: rtl/bsr_regs.sv
// Address, bit offset and control state; decides when a fetch starts.
module bsr_regs
  import bsr_pkg::*;
#(
  parameter  int ADDR_W     = 24,
  parameter  int LEN_W      = 4,
  localparam int ADDR_BYTES = ADDR_W / 8,
  localparam int SEL_W      = $clog2(ADDR_BYTES + 1),
  localparam int WIN_BYTES  = (1 << LEN_W) / 8,
  localparam int RD_W       = $clog2(WIN_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  byte_t             wr_data,
  input  logic              rd_en,
  input  logic [RD_W-1:0]   rd_sel,
  input  logic              busy,
  output logic              start_o,
  output logic [ADDR_W-1:0] base_o,
  output logic [LEN_W-1:0]  shift_o
);
  localparam int LW1 = LEN_W + 1;

  logic [ADDR_W-1:0] addr_q, addr_wr_val, addr_step;
  logic [LEN_W-1:0]  bitpos_q, len_q, len_field, shift_q;
  logic              auto_q, start_q;
  logic [LEN_W:0]    len_full, pos_sum;
  logic              wr_ok, ctrl_wr, addr_wr, auto_rd;

  assign wr_ok   = wr_en && !busy;
  assign ctrl_wr = wr_ok && (wr_sel == SEL_W'(CTRL_SEL));
  assign addr_wr = wr_ok && (wr_sel != SEL_W'(CTRL_SEL)) && (int'(wr_sel) <= ADDR_BYTES);
  assign auto_rd = rd_en && auto_q && (rd_sel == RD_W'(WIN_BYTES - 1)) && !busy && !wr_ok;

  // a control write uses its own new length
  assign len_field = ctrl_wr ? wr_data[LEN_W-1:0] : len_q;
  assign len_full  = (len_field == '0) ? LW1'(1 << LEN_W) : {1'b0, len_field};
  assign pos_sum   = {1'b0, bitpos_q} + len_full;
  assign addr_step = pos_sum[LEN_W] ? addr_q + ADDR_W'(WIN_BYTES) : addr_q;

  always_comb begin
    addr_wr_val = addr_q;
    for (int k = 0; k < ADDR_BYTES; k++) begin
      if (int'(wr_sel) == k + 1) addr_wr_val[8*k +: 8] = wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q   <= '0;
      bitpos_q <= '0;
      len_q    <= '0;
      auto_q   <= 1'b0;
      shift_q  <= '0;
      start_q  <= 1'b0;
    end else begin
      start_q <= 1'b0;
      if (ctrl_wr) begin
        len_q    <= wr_data[LEN_W-1:0];
        auto_q   <= wr_data[CTRL_AUTO_BIT];
        addr_q   <= addr_step;
        bitpos_q <= pos_sum[LEN_W-1:0];
        shift_q  <= pos_sum[LEN_W-1:0];
        start_q  <= 1'b1;
      end else if (addr_wr) begin
        addr_q   <= addr_wr_val;
        bitpos_q <= '0;
        shift_q  <= '0;
        start_q  <= 1'b1;
      end else if (auto_rd) begin
        addr_q   <= addr_step;
        bitpos_q <= pos_sum[LEN_W-1:0];
        shift_q  <= pos_sum[LEN_W-1:0];
        start_q  <= 1'b1;
      end
    end
  end

  assign start_o = start_q;
  assign base_o  = addr_q;
  assign shift_o = shift_q;
endmodule

// File: rtl/bsr_fetch.sv
// Issues FETCH_BYTES sequential byte reads and assembles a little-endian word.
module bsr_fetch #(
  parameter  int ADDR_W      = 24,
  parameter  int FETCH_BYTES = 4,
  localparam int WORD_W      = FETCH_BYTES * 8,
  localparam int CNT_W       = $clog2(FETCH_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_i,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic              active_o,
  output logic              done_o,
  output logic [WORD_W-1:0] word_o
);
  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  req_cnt_q, rsp_cnt_q;
  logic              active_q, rsp_vld_q;
  logic [WORD_W-1:0] word_q;

  assign mem_req  = active_q && (req_cnt_q != CNT_W'(FETCH_BYTES));
  assign mem_addr = base_q + ADDR_W'(req_cnt_q);
  assign done_o   = rsp_vld_q && (rsp_cnt_q == CNT_W'(FETCH_BYTES - 1));
  assign active_o = active_q;

  always_comb begin
    word_o = word_q;
    if (rsp_vld_q) word_o[8*int'(rsp_cnt_q) +: 8] = mem_rdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q    <= '0;
      req_cnt_q <= '0;
      rsp_cnt_q <= '0;
      active_q  <= 1'b0;
      rsp_vld_q <= 1'b0;
      word_q    <= '0;
    end else begin
      rsp_vld_q <= mem_req;
      if (start) begin
        base_q    <= base_i;
        req_cnt_q <= '0;
        rsp_cnt_q <= '0;
        active_q  <= 1'b1;
      end else begin
        if (mem_req) req_cnt_q <= req_cnt_q + 1'b1;
        if (rsp_vld_q) begin
          word_q    <= word_o;
          rsp_cnt_q <= rsp_cnt_q + 1'b1;
          if (done_o) active_q <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/bsr_align.sv
// Shifts the fetched word into the window and serves byte reads.
module bsr_align #(
  parameter  int LEN_W       = 4,
  parameter  int FETCH_BYTES = 4,
  localparam int WORD_W      = FETCH_BYTES * 8,
  localparam int WIN_W       = 1 << LEN_W,
  localparam int RD_W        = $clog2(WIN_W / 8)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] word_i,
  input  logic [LEN_W-1:0]  shift_i,
  input  logic              rd_en,
  input  logic [RD_W-1:0]   rd_sel,
  output logic [7:0]        rd_data
);
  logic [WIN_W-1:0]  window_q;
  logic [WORD_W-1:0] shifted;
  logic [7:0]        rd_q;

  assign shifted = word_i >> shift_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      window_q <= '0;
      rd_q     <= '0;
    end else begin
      if (rd_en) rd_q <= window_q[8*int'(rd_sel) +: 8];
      if (load)  window_q <= shifted[WIN_W-1:0];
    end
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/bitstream_window_reader.sv
module bitstream_window_reader #(
  parameter  int ADDR_W      = 24,
  parameter  int LEN_W       = 4,
  parameter  int FETCH_BYTES = 4,
  localparam int ADDR_BYTES  = ADDR_W / 8,
  localparam int SEL_W       = $clog2(ADDR_BYTES + 1),
  localparam int RD_W        = $clog2((1 << LEN_W) / 8),
  localparam int WORD_W      = FETCH_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  input  logic [RD_W-1:0]   rd_sel,
  output logic [7:0]        rd_data,
  output logic              busy,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata
);
  logic              start, active, done;
  logic [ADDR_W-1:0] base;
  logic [LEN_W-1:0]  shift;
  logic [WORD_W-1:0] word;

  assign busy = start || active;

  bsr_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_en(rd_en), .rd_sel(rd_sel), .busy(busy),
    .start_o(start), .base_o(base), .shift_o(shift)
  );

  bsr_fetch #(.ADDR_W(ADDR_W), .FETCH_BYTES(FETCH_BYTES)) u_fetch (
    .clk(clk), .rst(rst), .start(start), .base_i(base),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .active_o(active), .done_o(done), .word_o(word)
  );

  bsr_align #(.LEN_W(LEN_W), .FETCH_BYTES(FETCH_BYTES)) u_align (
    .clk(clk), .rst(rst), .load(done), .word_i(word), .shift_i(shift),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data)
  );
endmodule

// File: rtl/bsr_checker.sv
module bsr_checker #(
  parameter int ADDR_W      = 24,
  parameter int FETCH_BYTES = 4,
  parameter int SEL_W       = 2,
  parameter int RD_W        = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [SEL_W-1:0]  wr_sel,
  input logic [7:0]        wr_data,
  input logic              rd_en,
  input logic [RD_W-1:0]   rd_sel,
  input logic [7:0]        rd_data,
  input logic              busy,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [7:0]        mem_rdata
);
  logic [7:0] req_seen_q;

  always_ff @(posedge clk) begin
    if (rst || !busy) req_seen_q <= '0;
    else if (mem_req) req_seen_q <= req_seen_q + 8'd1;
  end

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (!busy && !mem_req && rd_data == 8'h00));

  p_req_in_busy_r6: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);

  p_addr_step_r6: assert property (@(posedge clk) disable iff (rst)
    (mem_req && $past(mem_req)) |-> (mem_addr == ADDR_W'($past(mem_addr) + 1)));

  p_four_reqs_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (req_seen_q == 8'(FETCH_BYTES)));

  p_rd_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

bind bitstream_window_reader bsr_checker #(
  .ADDR_W(ADDR_W), .FETCH_BYTES(FETCH_BYTES), .SEL_W(SEL_W), .RD_W(RD_W)
) u_chk (.*);

// File: tb/test_bitstream_window_reader.sv
module test_bitstream_window_reader;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [7:0]  wr_data = '0;
  logic        rd_en = 1'b0;
  logic [0:0]  rd_sel = '0;
  logic [7:0]  rd_data;
  logic        busy;
  logic        mem_req;
  logic [23:0] mem_addr;
  logic [7:0]  mem_rdata = '0;

  int checks = 0;
  int failures = 0;
  int req_seen = 0;

  logic [23:0] m_addr = '0;
  logic [3:0]  m_pos = '0;
  logic [7:0]  m_ctrl = '0;

  logic [15:0] exp_q[$];
  logic [15:0] act_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;  // 50 MHz

  bitstream_window_reader i_bitstream_window_reader (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data), .busy(busy),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] mem_byte(input logic [23:0] a);
    return 8'(a[7:0] * 8'd29 + a[15:8] * 8'd7 + a[23:16] * 8'd3 + 8'h5A);
  endfunction

  // synchronous memory model: one byte, one cycle after the request
  always @(posedge clk) if (mem_req) mem_rdata <= mem_byte(mem_addr);

  always @(negedge clk) if (mem_req) req_seen++;

  function automatic logic [15:0] exp_window(input logic [23:0] a, input logic [3:0] s);
    logic [31:0] w;
    w = {mem_byte(a + 24'd3), mem_byte(a + 24'd2), mem_byte(a + 24'd1), mem_byte(a)};
    return 16'(w >> s);
  endfunction

  task automatic check_val(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    while (act_q.size() > 0 && exp_q.size() > 0) begin
      logic [15:0] a, e;
      string t;
      a = act_q.pop_front();
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check_val(t, 32'(a), 32'(e));
    end
  end

  // every task starts and ends on a falling edge
  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [7:0] v);
    rd_en = 1'b1; rd_sel = sel;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic model_step();
    logic [4:0] len, sum;
    len = (m_ctrl[3:0] == 4'd0) ? 5'd16 : {1'b0, m_ctrl[3:0]};
    sum = {1'b0, m_pos} + len;
    if (sum[4]) m_addr = m_addr + 24'd2;
    m_pos = sum[3:0];
  endtask

  task automatic finish_fetch(input string tag);
    check_val({tag, " busy"}, 32'(busy), 32'd1);
    wait_idle();
    check_val({tag, " req count"}, req_seen, 4);
  endtask

  task automatic op_wr_addr(input logic [1:0] sel, input logic [7:0] d);
    req_seen = 0;
    wr(sel, d);
    m_addr[8*(int'(sel)-1) +: 8] = d;
    m_pos = '0;
    finish_fetch("R6 addr");
  endtask

  task automatic op_wr_ctrl(input logic [7:0] d);
    req_seen = 0;
    wr(2'd0, d);
    m_ctrl = d;
    model_step();
    finish_fetch("R6 ctrl");
  endtask

  // read both bytes; in auto mode the high read advances the stream (R4)
  task automatic expect_now(input string tag);
    logic [7:0] lo, hi;
    exp_q.push_back(exp_window(m_addr, m_pos));
    tag_q.push_back(tag);
    rd(1'b0, lo);
    rd(1'b1, hi);
    act_q.push_back({hi, lo});
    if (m_ctrl[7]) begin
      model_step();
      wait_idle();
    end
  endtask

  initial begin
    #(20 * 100000);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [15:0] old;
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check_val("R1 busy", 32'(busy), 0);
    check_val("R1 mem_req", 32'(mem_req), 0);
    rd(1'b0, v); check_val("R1 low byte", 32'(v), 0);
    rd(1'b1, v); check_val("R1 high byte", 32'(v), 0);

    // R2 address bytes, unshifted fetch
    op_wr_addr(2'd1, 8'h23);
    op_wr_addr(2'd2, 8'h01);
    op_wr_addr(2'd3, 8'h00);
    expect_now("R2 addr 000123");
    op_wr_addr(2'd1, 8'h40);
    expect_now("R2 addr 000140");

    // R3 control writes: plain, crossing 16, length 0 as 16
    op_wr_ctrl(8'h05); expect_now("R3 len5");
    op_wr_ctrl(8'h07); expect_now("R3 len7");
    op_wr_ctrl(8'h09); expect_now("R3 cross16");
    op_wr_ctrl(8'h00); expect_now("R3 len0 is 16");
    op_wr_ctrl(8'h0F); expect_now("R3 len15");

    // R5 reads do not advance without auto mode
    expect_now("R5 first read");
    expect_now("R5 repeat read");

    // R8 read while busy returns the previous window
    old = exp_window(m_addr, m_pos);
    req_seen = 0;
    wr(2'd0, 8'h03);
    rd(1'b0, v);
    check_val("R8 low during busy", 32'(v), 32'(old[7:0]));
    rd(1'b1, v);
    check_val("R8 high during busy", 32'(v), 32'(old[15:8]));
    m_ctrl = 8'h03; model_step();
    wait_idle();
    expect_now("R8 after fetch");

    // R7 writes during busy are dropped
    wr(2'd0, 8'h02);
    m_ctrl = 8'h02; model_step();
    wr(2'd1, 8'h77);
    wr(2'd0, 8'h8F);
    wait_idle();
    expect_now("R7 window");
    op_wr_ctrl(8'h01); expect_now("R7 address kept");

    // R4 auto-advance on high byte read
    op_wr_ctrl(8'h84);
    expect_now("R4 auto len4 a");
    expect_now("R4 auto len4 b");
    expect_now("R4 auto len4 c");
    op_wr_ctrl(8'h8C);
    expect_now("R4 auto len12 a");
    expect_now("R4 auto len12 b");
    op_wr_ctrl(8'h06); expect_now("R4 auto off");

    // R6 address wrap at the top of the space
    op_wr_addr(2'd3, 8'hFF);
    op_wr_addr(2'd2, 8'hFF);
    op_wr_addr(2'd1, 8'hFE);
    expect_now("R6 wrap fetch");
    op_wr_ctrl(8'h00); expect_now("R6 wrap advance");

    // R9 registered read data holds without a strobe
    rd(1'b1, v);
    repeat (3) @(negedge clk);
    check_val("R9 hold", 32'(rd_data), 32'(v));
    check_val("R9 high lane", 32'(v), 32'(exp_window(m_addr, m_pos) >> 8));

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule